// File: doc/BRIEF.md
# Seconds Real-Time Clock With Alarm Compare

This block keeps a free-running seconds count and raises an alarm interrupt when the count reaches a programmed value. Software reaches it over a byte-wide register port made of an address, a write strobe, write data and combinational read data. The count moves forward by one on each pulse of a once-per-second tick input, but only while the run-enable bit is set.

The time is set in stages. Software writes the upper bytes of the new value into a staging bank, then writes the lowest byte last. That last write copies the whole value into the counter in one step. The read bank shows the live counter bytes and takes no snapshot, so software must detect a carry between byte reads itself: a lowest byte that reads smaller than it did earlier means the count moved on between reads.

The alarm fires on a tick whose incremented count equals the compare bank while the alarm-enable bit is set. It stays pending until software writes the clear bit. The interrupt output is a level that follows the pending flag, so a handler triggered on its rising edge sees one edge per alarm.

Top module: `rtc_seconds`

## Requirements
- R1: After reset the counter, the staging bank, the compare bank and both control registers read 0x00, `irq_o` is low, and ticks have no effect until the run bit is set.
- R2: The register map is as follows. Offset 0x00 is the control register. Offset 0x01 is the alarm control register. The write staging bank sits at 0x02..0x05, the live read bank at 0x06..0x09 and the alarm compare bank at 0x0A..0x0D. Every bank is little-endian, with the lowest offset holding bits 7:0. The compare bank reads back what was written. Offsets 0x0E and 0x0F read 0x00.
- R3: On a cycle with `tick_i` high, the counter increments by one only if control bit 7 (run) is 1. Otherwise it holds.
- R4: A write to staging bytes 1..3 (0x03..0x05) changes only the staging bank, which reads back the written byte. The counter does not change.
- R5: A write to staging byte 0 (0x02) loads the counter with the written byte in bits 7:0 and staging bytes 1..3 above it. The new value is visible in the read bank on the next cycle. A load in the same cycle as a tick takes priority, and that tick is dropped.
- R6: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R7: The read bank returns the live counter bytes. A tick between two reads of 0x06 can make the second read smaller, with the carry visible in 0x07.
- R8: The pending flag sets on a tick where the counter, after incrementing, equals the compare value while alarm-control bit 1 (alarm enable) is 1. `irq_o` equals the pending flag. Reading 0x01 returns the pending flag in bit 0.
- R9: With the alarm enable at 0, reaching the compare value leaves `irq_o` low.
- R10: Writing 0x01 with bit 0 = 1 clears the pending flag, and bit 0 = 0 leaves it alone. Bits 7:1 keep the written value. If a clear and a new alarm fall in the same cycle, the alarm wins.
- R11: Loading the counter with a value equal to the compare value does not set the pending flag; only a tick does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| addr_i | input | AW (4) | Register offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The bench builds the block with its default parameters: a four-byte counter and a four-bit address. With these the full register window, including the two unmapped offsets, is reachable. The wrap from all-ones is reached in one tick by loading 0xFFFFFFFF through the staging bank rather than by counting. The lowest-byte rollover exposes the unlatched carry. The alarm is driven into its coincident cases: a clear in the same cycle as a matching tick, and a load that lands exactly on the compare value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFF_CTRL    = 0;
  localparam int unsigned OFF_ALM     = 1;
  localparam int unsigned OFF_WR_BASE = 2;
  localparam int unsigned RUN_BIT     = 7;
  localparam int unsigned ALM_EN_BIT  = 1;
  localparam int unsigned ALM_CLR_BIT = 0;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] next_o,
  output logic          step_o
);
  logic [CW-1:0] cnt_q;

  assign next_o = cnt_q + CW'(1);
  // load wins over a coincident tick
  assign step_o = tick_i & run_i & ~load_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_o) cnt_q <= next_o;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] next_i,
  input  logic [CW-1:0] match_i,
  input  logic          en_i,
  input  logic          clr_i,
  output logic          pend_o
);
  logic pend_q;
  logic hit;

  assign hit = step_i & en_i & (next_i == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (hit)    pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned AW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          irq_o
);
  import rtc_pkg::*;

  localparam int unsigned CW      = 8 * NBYTES;
  localparam int unsigned WR_BASE = OFF_WR_BASE;
  localparam int unsigned RD_BASE = WR_BASE + NBYTES;
  localparam int unsigned AL_BASE = RD_BASE + NBYTES;

  logic [7:0]    ctrl_q;
  logic [7:1]    alm_bits_q;
  logic [7:0]    stage_q [NBYTES];
  logic [7:0]    match_q [NBYTES];
  logic [CW-1:0] match_val;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_next;
  logic          step;
  logic          pend;
  logic          load;
  logic          alm_wr;
  logic          run;
  logic          alm_en;

  assign run    = ctrl_q[RUN_BIT];
  assign alm_en = alm_bits_q[ALM_EN_BIT];
  assign load   = we_i && (addr_i == AW'(WR_BASE));
  assign alm_wr = we_i && (addr_i == AW'(OFF_ALM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      alm_bits_q <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(OFF_CTRL)) ctrl_q     <= wdata_i;
      if (alm_wr)                  alm_bits_q <= wdata_i[7:1];
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[b] <= '0;
        match_q[b] <= '0;
      end else if (we_i) begin
        if (addr_i == AW'(WR_BASE + b)) stage_q[b] <= wdata_i;
        if (addr_i == AW'(AL_BASE + b)) match_q[b] <= wdata_i;
      end
    end
    assign match_val[8*b +: 8] = match_q[b];
    if (b == 0) begin : g_lsb
      assign load_val[7:0] = wdata_i;
    end else begin : g_upper
      assign load_val[8*b +: 8] = stage_q[b];
    end
  end

  rtc_sec_counter #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .next_o     (cnt_next),
    .step_o     (step)
  );

  rtc_alarm #(.CW(CW)) u_alm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .next_i  (cnt_next),
    .match_i (match_val),
    .en_i    (alm_en),
    .clr_i   (alm_wr & wdata_i[ALM_CLR_BIT]),
    .pend_o  (pend)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == AW'(OFF_CTRL)) rdata_o = ctrl_q;
    if (addr_i == AW'(OFF_ALM))  rdata_o = {alm_bits_q, pend};
    for (int b = 0; b < NBYTES; b++) begin
      if (addr_i == AW'(WR_BASE + b)) rdata_o = stage_q[b];
      if (addr_i == AW'(RD_BASE + b)) rdata_o = cnt[8*b +: 8];
      if (addr_i == AW'(AL_BASE + b)) rdata_o = match_q[b];
    end
  end

  assign irq_o = pend;
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk #(
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 4,
  parameter int unsigned WR0 = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic          run_i,
  input logic          alm_en_i,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] match_i,
  input logic          irq_o
);
  logic ld;
  assign ld = we_i && (addr_i == AW'(WR0));

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !(tick_i && run_i)) |=> $stable(cnt_i));

  // R5
  load_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (cnt_i[7:0] == $past(wdata_i)));

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i && !ld && (cnt_i == '1)) |=> (cnt_i == '0));

  // R8
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((cnt_i == match_i) && $past(alm_en_i)));

  // R9
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alm_en_i && !irq_o) |=> !irq_o);

  // R10
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == AW'(1)) && wdata_i[0] && !tick_i) |=> !irq_o);
endmodule

bind rtc_seconds rtc_seconds_chk #(.CW(CW), .AW(AW), .WR0(WR_BASE)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .run_i    (run),
  .alm_en_i (alm_en),
  .cnt_i    (cnt),
  .match_i  (match_val),
  .irq_o    (irq_o)
);

// File: tb/rtc_seconds_tb_top.sv
`timescale 1ns/1ps
module rtc_seconds_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rtc_seconds dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_cnt, m_alarm;
  logic [31:0] m_stage;
  logic [7:0]  m_ctrl, m_actl;
  logic        m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_alarm = 0; m_stage = 0; m_ctrl = 0; m_actl = 0; m_pend = 0;
    end else begin
      automatic bit ld   = we && addr == 4'd2;
      automatic bit step = tick && m_ctrl[7] && !ld;
      automatic logic [31:0] nx = m_cnt + 1;
      automatic bit hit  = step && m_actl[1] && nx == m_alarm;
      automatic bit clr  = we && addr == 4'd1 && wdata[0];
      if (ld) m_cnt = {m_stage[31:8], wdata};
      else if (step) m_cnt = nx;
      if (we) begin
        if (addr == 0) m_ctrl = wdata;
        if (addr == 1) m_actl = {wdata[7:1], 1'b0};
        if (addr >= 2 && addr <= 5) m_stage[8*(addr-2) +: 8] = wdata;
        if (addr >= 10 && addr <= 13) m_alarm[8*(addr-10) +: 8] = wdata;
      end
      if (hit) m_pend = 1;
      else if (clr) m_pend = 0;
    end
  end

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a == 0) return m_ctrl;
    if (a == 1) return {m_actl[7:1], m_pend};
    if (a >= 2 && a <= 5)   return m_stage[8*(a-2) +: 8];
    if (a >= 6 && a <= 9)   return m_cnt[8*(a-6) +: 8];
    if (a >= 10 && a <= 13) return m_alarm[8*(a-10) +: 8];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // compared on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R8 irq vs model", irq, m_pend);
      chk("R2 rdata vs model", rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit t = 0);
    @(negedge clk); addr = a; we = 1; wdata = d; tick = t;
    @(negedge clk); we = 0; tick = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we = 0; #1; d = rdata;
  endtask

  task automatic rd32(input logic [3:0] base, output logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      rd(base + 4'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic load32(input logic [31:0] v);
    wr(4'd3, v[15:8]); wr(4'd4, v[23:16]); wr(4'd5, v[31:24]); wr(4'd2, v[7:0]);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(4'd0, b); chk("R1 ctrl", b, 0);
    rd(4'd1, b); chk("R1 alarm ctrl", b, 0);
    rd32(4'd6, v); chk("R1 counter", v, 0);
    chk("R1 irq", irq, 0);
    ticks(2); rd32(4'd6, v); chk("R1 stopped after reset", v, 0);
    // R2
    rd(4'd14, b); chk("R2 unmapped 0x0E", b, 0);
    rd(4'd15, b); chk("R2 unmapped 0x0F", b, 0);
    wr(4'd10, 8'h11); wr(4'd11, 8'h22); wr(4'd12, 8'h33); wr(4'd13, 8'h44);
    rd32(4'd10, v); chk("R2 compare bank", v, 32'h44332211);
    // R4
    wr(4'd3, 8'hAB); wr(4'd4, 8'hCD); wr(4'd5, 8'hEF);
    rd32(4'd6, v); chk("R4 counter unchanged", v, 0);
    rd(4'd3, b); chk("R4 staging readback", b, 8'hAB);
    // R5
    wr(4'd2, 8'h12);
    rd32(4'd6, v); chk("R5 load", v, 32'hEFCDAB12);
    // R3
    ticks(3); rd32(4'd6, v); chk("R3 run off holds", v, 32'hEFCDAB12);
    wr(4'd0, 8'h80);
    ticks(3); rd32(4'd6, v); chk("R3 run on advances", v, 32'hEFCDAB15);
    // R5 load beats tick
    wr(4'd2, 8'h50, 1);
    rd32(4'd6, v); chk("R5 load priority", v, 32'hEFCDAB50);
    // R6
    load32(32'hFFFFFFFF); ticks(1);
    rd32(4'd6, v); chk("R6 wrap", v, 0);
    // R7
    load32(32'h000000FF);
    rd(4'd6, b); chk("R7 lsb before", b, 8'hFF);
    ticks(1);
    rd(4'd6, b); chk("R7 lsb after carry", b, 8'h00);
    rd(4'd7, b); chk("R7 carry byte", b, 8'h01);
    // R9
    wr(4'd10, 8'h05); wr(4'd11, 0); wr(4'd12, 0); wr(4'd13, 0);
    load32(32'd3); ticks(2);
    chk("R9 no alarm when disabled", irq, 0);
    // R8
    load32(32'd3); wr(4'd1, 8'h02);
    ticks(1); chk("R8 before match", irq, 0);
    ticks(1); chk("R8 at match", irq, 1);
    rd(4'd1, b); chk("R8 status bit", b, 8'h03);
    ticks(1); chk("R8 level held", irq, 1);
    // R10
    wr(4'd1, 8'h02); chk("R10 bit0 zero keeps", irq, 1);
    wr(4'd1, 8'hA3); chk("R10 clear", irq, 0);
    rd(4'd1, b); chk("R10 bits preserved", b, 8'hA2);
    // R11
    load32(32'd5); chk("R11 load match no alarm", irq, 0);
    // R10 coincident set and clear
    load32(32'd4); wr(4'd1, 8'h03, 1);
    chk("R10 set beats clear", irq, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule